// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block raises the interrupts of a real-time clock. It takes three event sources. A periodic source comes from a free-running divider of a fast base tick, and its period is picked by a small rate code. An alarm source compares the current seconds, minutes and hours with programmed alarm values, and any alarm field can be set to match every value. An update-ended source fires on a pulse from the calendar logic. Calendar counting is done elsewhere. The periodic divider also drives an optional square-wave output.

Each source sets its own flag in an 8-bit status byte. Software reads that byte through a one-cycle read strobe, and the read clears every flag. The top bit of the byte combines the flags whose sources are enabled, and the same value drives the interrupt request line. The flags are recorded whatever the enables are, so software polling still sees every event.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, `stat_o` reads 0x00 and both `irq_o` and `sqw_o` are low.
- R2: With a rate code n from 1 to 15 and `base_tick_i` high, a periodic event occurs once every 2^n base ticks and sets status bit 6.
- R3: Rate code 0 produces no periodic events, so bit 6 stays clear.
- R4: While `sqw_en_i` is high, `sqw_o` toggles on every periodic event. While `sqw_en_i` is low, `sqw_o` is low.
- R5: On a `sec_tick_i` cycle, status bit 5 sets when each of the three alarm fields either equals its current field or has both of its top two bits set (0xC0 matches anything).
- R6: A `sec_tick_i` cycle in which any field that is not a wildcard differs from its current field leaves bit 5 clear.
- R7: A pulse on `upd_done_i` sets status bit 4.
- R8: Bits 6, 5 and 4 set whatever the enables are. Bit 7 is the OR of each flag ANDed with its enable (`per_en_i`, `alm_en_i`, `upd_en_i`), and `irq_o` equals bit 7.
- R9: A cycle with `stat_rd_i` high returns the current status on `stat_o` and clears all flags on the following edge.
- R10: If an event arrives in the same cycle as a read, the read returns the old value and that event's flag is set afterwards.
- R11: Status bits 3 to 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Base tick enable that feeds the periodic divider |
| sec_tick_i | input | 1 | One-cycle pulse when new time fields are valid |
| upd_done_i | input | 1 | One-cycle pulse when a calendar update has finished |
| sec_i | input | FIELD_W | Current seconds |
| min_i | input | FIELD_W | Current minutes |
| hour_i | input | FIELD_W | Current hours |
| alm_sec_i | input | FIELD_W | Alarm seconds |
| alm_min_i | input | FIELD_W | Alarm minutes |
| alm_hour_i | input | FIELD_W | Alarm hours |
| rate_sel_i | input | RATE_W | Periodic rate code; 0 turns the source off |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| upd_en_i | input | 1 | Update-ended interrupt enable |
| sqw_en_i | input | 1 | Square-wave output enable |
| stat_rd_i | input | 1 | Status read strobe; clears the flags |
| stat_o | output | 8 | Status byte: 7 request, 6 periodic, 5 alarm, 4 update, 3:0 zero |
| irq_o | output | 1 | Interrupt request |
| sqw_o | output | 1 | Square-wave output |

## Verification
The bench uses the default parameters: 8-bit time fields and a 4-bit rate code, which gives a 15-bit divider. It holds the base tick high on every clock, so even the slowest code (2^15 ticks) finishes two full periods within the run. That lets the bench measure the exact interval for the fastest, a middle and the slowest code, and check the square-wave toggle against those intervals. With the divider stopped, the alarm, update and read-collision cases run without stray periodic events.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned ST_IRQ = 7;
  localparam int unsigned ST_PER = 6;
  localparam int unsigned ST_ALM = 5;
  localparam int unsigned ST_UPD = 4;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sqw_en_i,
  output logic              evt_o,
  output logic              sqw_o
);
  localparam int unsigned CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] mask;
  logic             sqw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // low rate_i bits all ones -> period of 2^rate_i ticks
  assign span  = ((CNT_W+1)'(1) << rate_i) - (CNT_W+1)'(1);
  assign mask  = span[CNT_W-1:0];
  assign evt_o = tick_i && (rate_i != '0) && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sqw_q <= 1'b0;
    else if (!sqw_en_i) sqw_q <= 1'b0;
    else if (evt_o)     sqw_q <= ~sqw_q;
  end

  assign sqw_o = sqw_q;

  // R4
  sqw_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqw_en_i |=> !sqw_o);
  // R4
  sqw_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sqw_en_i && evt_o) |=> (sqw_o != $past(sqw_o)));
  // R3
  rate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |-> !evt_o);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned N_FIELDS = 3
) (
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] cur_i,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] alm_i,
  input  logic                             sec_tick_i,
  output logic                             evt_o
);
  logic [N_FIELDS-1:0] hit;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    logic wild;
    assign wild   = &alm_i[g][FIELD_W-1:FIELD_W-2];
    assign hit[g] = wild || (alm_i[g] == cur_i[g]);
  end

  assign evt_o = sec_tick_i && (&hit);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  evt_t              evt_i,
  input  evt_t              en_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] stat_o
);
  evt_t flg_q;
  evt_t flg_d;
  logic req;

  // read clears, but a same-cycle event survives
  assign flg_d = rd_i ? evt_i : (flg_q | evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign req = |(flg_q & en_i);

  always_comb begin
    stat_o         = '0;
    stat_o[ST_IRQ] = req;
    stat_o[ST_PER] = flg_q.per;
    stat_o[ST_ALM] = flg_q.alm;
    stat_o[ST_UPD] = flg_q.upd;
  end

  // R2
  per_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.per |=> stat_o[ST_PER]);
  // R5
  alm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.alm |=> stat_o[ST_ALM]);
  // R9
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !evt_i.upd) |=> !stat_o[ST_UPD]);
  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_ALM] && !rd_i) |=> stat_o[ST_ALM]);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned RATE_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_tick_i,
  input  logic               sec_tick_i,
  input  logic               upd_done_i,
  input  logic [FIELD_W-1:0] sec_i,
  input  logic [FIELD_W-1:0] min_i,
  input  logic [FIELD_W-1:0] hour_i,
  input  logic [FIELD_W-1:0] alm_sec_i,
  input  logic [FIELD_W-1:0] alm_min_i,
  input  logic [FIELD_W-1:0] alm_hour_i,
  input  logic [RATE_W-1:0]  rate_sel_i,
  input  logic               per_en_i,
  input  logic               alm_en_i,
  input  logic               upd_en_i,
  input  logic               sqw_en_i,
  input  logic               stat_rd_i,
  output logic [7:0]         stat_o,
  output logic               irq_o,
  output logic               sqw_o
);
  localparam int unsigned N_FIELDS = 3;

  evt_t evt;
  evt_t en;
  logic [N_FIELDS-1:0][FIELD_W-1:0] cur_f;
  logic [N_FIELDS-1:0][FIELD_W-1:0] alm_f;
  logic [STAT_W-1:0] stat;

  assign cur_f   = {hour_i, min_i, sec_i};
  assign alm_f   = {alm_hour_i, alm_min_i, alm_sec_i};
  assign en      = '{per: per_en_i, alm: alm_en_i, upd: upd_en_i};
  assign evt.upd = upd_done_i;

  rtc_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (base_tick_i),
    .rate_i   (rate_sel_i),
    .sqw_en_i (sqw_en_i),
    .evt_o    (evt.per),
    .sqw_o    (sqw_o)
  );

  rtc_alarm_match #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_alm (
    .cur_i      (cur_f),
    .alm_i      (alm_f),
    .sec_tick_i (sec_tick_i),
    .evt_o      (evt.alm)
  );

  rtc_irq_flags u_flg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .en_i   (en),
    .rd_i   (stat_rd_i),
    .stat_o (stat)
  );

  assign stat_o = stat;
  assign irq_o  = stat[ST_IRQ];

  // R8
  masked_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_en_i && !alm_en_i && !upd_en_i) |-> !irq_o);
  // R11
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3:0] == 4'h0);
endmodule

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0, sec_tick = 1'b0, upd_done = 1'b0;
  logic [7:0] sec = '0, mn = '0, hr = '0;
  logic [7:0] a_sec = '0, a_min = '0, a_hr = '0;
  logic [3:0] rate = '0;
  logic per_en = 1'b0, alm_en = 1'b0, upd_en = 1'b0, sqw_en = 1'b0;
  logic rd = 1'b0;
  logic [7:0] stat;
  logic irq, sqw;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(base_tick), .sec_tick_i(sec_tick),
    .upd_done_i(upd_done), .sec_i(sec), .min_i(mn), .hour_i(hr),
    .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hr), .rate_sel_i(rate),
    .per_en_i(per_en), .alm_en_i(alm_en), .upd_en_i(upd_en), .sqw_en_i(sqw_en),
    .stat_rd_i(rd), .stat_o(stat), .irq_o(irq), .sqw_o(sqw)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_stat(output logic [7:0] v);
    @(negedge clk);
    rd = 1'b1;
    v = stat;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 stat", stat, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sqw", sqw, 0);
  endtask

  task automatic measure(logic [3:0] code, bit use_sqw);
    logic [7:0] v;
    logic s0;
    int k;
    rate = code;
    sqw_en = use_sqw;
    base_tick = 1'b1;
    read_stat(v);
    k = 0;
    while (!stat[6] && k < 70000) begin
      @(negedge clk);
      k++;
    end
    s0 = sqw;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    k = 1;
    while (!stat[6] && k < 70000) begin
      @(negedge clk);
      k++;
    end
    chk($sformatf("R2 period code %0d", code), k, 1 << code);
    if (use_sqw) chk("R4 sqw toggles per event", sqw != s0, 1);
    read_stat(v);
  endtask

  task automatic t_rate_off;
    logic [7:0] v;
    bit seen = 1'b0;
    rate = 4'd0;
    base_tick = 1'b1;
    sqw_en = 1'b1;
    read_stat(v);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (stat[6] || sqw) seen = 1'b1;
    end
    chk("R3 code 0 no periodic event", seen, 0);
    rate = 4'd1;
    sqw_en = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sqw) seen = 1'b1;
    end
    chk("R4 sqw low when disabled", seen, 0);
    base_tick = 1'b0;
    rate = 4'd0;
    read_stat(v);
  endtask

  task automatic sec_pulse;
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    sec = 8'h30; mn = 8'h15; hr = 8'h09;
    a_sec = 8'h30; a_min = 8'h15; a_hr = 8'h09;
    @(negedge clk);
    chk("R5 no flag without sec tick", stat[5], 0);
    sec_pulse();
    chk("R5 exact match", stat, 8'h20);
    read_stat(v);
    a_sec = 8'h31;
    sec_pulse();
    chk("R6 seconds mismatch", stat[5], 0);
    a_sec = 8'hC0; a_min = 8'hC0; sec = 8'h47; mn = 8'h02;
    sec_pulse();
    chk("R5 wildcard fields", stat[5], 1);
    read_stat(v);
    hr = 8'h10;
    sec_pulse();
    chk("R6 hour mismatch with wildcards", stat[5], 0);
    a_hr = 8'hC0;
    sec_pulse();
    chk("R5 all wildcards", stat, 8'h20);
    read_stat(v);
    chk("R9 read returns old value", v, 8'h20);
    chk("R9 read clears", stat, 8'h00);
  endtask

  task automatic t_enables;
    logic [7:0] v;
    @(negedge clk);
    upd_done = 1'b1;
    @(negedge clk);
    upd_done = 1'b0;
    chk("R7 update flag", stat, 8'h10);
    chk("R8 irq masked", irq, 0);
    per_en = 1'b1;
    alm_en = 1'b1;
    #1;
    chk("R8 other enables do not raise bit 7", stat, 8'h10);
    upd_en = 1'b1;
    #1;
    chk("R8 enabled flag raises bit 7", stat, 8'h90);
    chk("R8 irq follows bit 7", irq, 1);
    chk("R11 low bits zero", stat[3:0], 0);
    read_stat(v);
    chk("R9 read value", v, 8'h90);
    chk("R9 cleared, irq low", {stat, 7'b0, irq}, 0);
    per_en = 1'b0; alm_en = 1'b0; upd_en = 1'b0;
  endtask

  task automatic t_collide;
    logic [7:0] v;
    sec_pulse();
    chk("R5 alarm preload", stat, 8'h20);
    @(negedge clk);
    rd = 1'b1;
    upd_done = 1'b1;
    v = stat;
    @(negedge clk);
    rd = 1'b0;
    upd_done = 1'b0;
    chk("R10 read returns old value", v, 8'h20);
    chk("R10 new event kept", stat, 8'h10);
    read_stat(v);
    chk("R10 kept flag then cleared", stat, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alarm();
    t_enables();
    t_collide();
    t_rate_off();
    measure(4'd1, 1'b1);
    measure(4'd3, 1'b1);
    measure(4'd5, 1'b0);
    measure(4'd15, 1'b1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule